// File: doc/BRIEF.md
# Hot-Plug Message Control and Status Register

This block is one 32-bit control and status word inside a PCI Express endpoint. It covers hot-plug indicator traffic and the reply to vendor-defined messages. Incoming attention-indicator and power-indicator control messages arrive as decoded one-cycle pulses, each with a two-bit indicator code. The block stores each code in its own read-only field and pulses a strobe that sets the hot-plug bit in the chip's interrupt status register. That strobe does not depend on any interrupt mask.

On the transmit side, software writes a 1 to one of two command bits. One asks for an attention-button-pressed message and the other asks for an unsupported-request reply to the logged vendor-defined message. A command bit drives a level request to the message transmitter. It stays set until the transmitter returns a one-cycle done pulse, and it clears on the edge that samples that pulse. When the unsupported-request reply completes, the block pulses a strobe that copies the logged header into the error header log and a strobe that sets the unsupported-request error status.

Top module: `hpm_csr`

## Requirements
- R1: After reset, every bit of `reg_rdata` reads 0, and `abp_req`, `ur_req`, `hp_int_set`, `hdr_copy` and `ur_err_set` are all low.
- R2: The attention field occupies `reg_rdata[31:30]` and the power field occupies `reg_rdata[29:28]`. The codes are 00 reserved, 01 on, 10 blink and 11 off. A software write to bits 31:28 leaves both fields unchanged.
- R3: A pulse on `rx_attn_msg` loads `rx_attn_code` into bits 31:30, and a pulse on `rx_pwr_msg` loads `rx_pwr_code` into bits 29:28. The new value is readable from the cycle after the pulse. Both fields can load in the same cycle, and neither load disturbs the other field.
- R4: Each cycle that carries at least one indicator message produces exactly one `hp_int_set` pulse, one cycle wide, in the following cycle. The block has no mask input, so no mask can suppress the pulse or the field update.
- R5: A write with bit 15 set while `endpoint_mode` is high sets the attention-button command. From the next cycle, bit 15 reads 1 and `abp_req` is high. The same write with `endpoint_mode` low has no effect.
- R6: A pending command stays set, with its request held high, until its done input pulses. It reads 0 from the cycle after the done pulse. A done pulse that arrives while no command is pending has no effect.
- R7: Writing 0 to a pending command bit does not cancel it. Writing 1 to a command bit that is already pending does not produce a second request after the first completes.
- R8: A write with bit 14 set raises `ur_req` and sets bit 14. On `ur_done` while that command is pending, `hdr_copy` and `ur_err_set` each pulse high for the single cycle after the done pulse, and bit 14 clears. A `ur_done` pulse with nothing pending produces neither strobe.
- R9: Bits 27:16 and 13:0 always read 0, and writes to them are ignored.
- R10: When a write and a message capture or a done pulse hit the same bit in the same cycle, the hardware event wins. The captured code is stored, and a pending command clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| endpoint_mode | input | 1 | High when the device operates as an endpoint; enables the attention-button command |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Current register contents |
| rx_attn_msg | input | 1 | Attention-indicator control message received (one-cycle pulse) |
| rx_attn_code | input | 2 | Indicator code carried by the attention message |
| rx_pwr_msg | input | 1 | Power-indicator control message received (one-cycle pulse) |
| rx_pwr_code | input | 2 | Indicator code carried by the power message |
| hp_int_set | output | 1 | Sets the hot-plug interrupt status bit (one-cycle pulse) |
| abp_req | output | 1 | Level request for an attention-button-pressed message |
| abp_done | input | 1 | Transmitter has sent the attention-button message (one-cycle pulse) |
| ur_req | output | 1 | Level request for the unsupported-request reply |
| ur_done | input | 1 | Transmitter has delivered the unsupported-request reply (one-cycle pulse) |
| hdr_copy | output | 1 | Copies the logged message header into the error header log (one-cycle pulse) |
| ur_err_set | output | 1 | Sets the unsupported-request error status (one-cycle pulse) |

## Verification
The bench sends all four indicator codes into each field, both alone and together. Each time, it also writes the inverted code through software. A design that let the write win, or that mixed up the two fields, would read back the wrong code. It also checks that the interrupt strobe is exactly one cycle wide, because a strobe that stays high would set the status bit again. For the command bits, the bench holds the requests across writes of 0 and repeated writes of 1. It sends stray done pulses while nothing is pending, and it places a write of 1 in the same cycle as done. A design that cancelled on a 0, armed a second message, or missed the self-clear would leave a request high or send the header-copy strobe twice.

// File: rtl/hpm_pkg.sv
package hpm_pkg;
  localparam int CSR_W    = 32;
  localparam int IND_W    = 2;
  localparam int ATTN_LSB = 30;
  localparam int PWR_LSB  = 28;
  localparam int ABP_BIT  = 15;
  localparam int UR_BIT   = 14;

  typedef enum logic [IND_W-1:0] {
    IND_RSVD  = 2'b00,
    IND_ON    = 2'b01,
    IND_BLINK = 2'b10,
    IND_OFF   = 2'b11
  } ind_code_e;

  // Places the live fields at their positions; every other bit is zero.
  function automatic logic [CSR_W-1:0] pack_csr(
    input logic [IND_W-1:0] attn,
    input logic [IND_W-1:0] pwr,
    input logic             abp,
    input logic             ur
  );
    logic [CSR_W-1:0] w;
    w = '0;
    w[ATTN_LSB +: IND_W] = attn;
    w[PWR_LSB  +: IND_W] = pwr;
    w[ABP_BIT]           = abp;
    w[UR_BIT]            = ur;
    return w;
  endfunction
endpackage

// File: rtl/hpm_ind_capture.sv
module hpm_ind_capture #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         msg,
  input  logic [W-1:0] code,
  output logic [W-1:0] field,
  output logic         hit
);
  // The capture event is brought out as a named wire.
  assign hit = msg;

  always_ff @(posedge clk) begin
    if (!rst_n)   field <= '0;
    else if (hit) field <= code;
  end

  AST_IND_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    msg |=> field == $past(code)); // R3
  AST_IND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !msg |=> $stable(field)); // R2
endmodule

// File: rtl/hpm_tx_cmd.sv
module hpm_tx_cmd (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic done,
  output logic pend,
  output logic finish
);
  logic arm;

  // A completion only counts while a command is pending.
  assign finish = pend & done;
  // A command arms only from idle, so a repeated write cannot queue a second one.
  assign arm    = set_req & ~pend;

  always_ff @(posedge clk) begin
    if (!rst_n)      pend <= 1'b0;
    else if (finish) pend <= 1'b0;
    else if (arm)    pend <= 1'b1;
  end

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pend && !done |=> pend); // R7
  AST_CMD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    pend && done |=> !pend); // R6
  AST_CMD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !pend && !set_req |=> !pend); // R6
endmodule

// File: rtl/hpm_csr.sv
module hpm_csr
  import hpm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             endpoint_mode,
  input  logic             reg_wr,
  input  logic [CSR_W-1:0] reg_wdata,
  output logic [CSR_W-1:0] reg_rdata,
  input  logic             rx_attn_msg,
  input  logic [IND_W-1:0] rx_attn_code,
  input  logic             rx_pwr_msg,
  input  logic [IND_W-1:0] rx_pwr_code,
  output logic             hp_int_set,
  output logic             abp_req,
  input  logic             abp_done,
  output logic             ur_req,
  input  logic             ur_done,
  output logic             hdr_copy,
  output logic             ur_err_set
);
  logic [IND_W-1:0] attn_q, pwr_q;
  logic             attn_hit, pwr_hit;
  logic             abp_wr, ur_wr;
  logic             abp_fin, ur_fin;
  logic             hp_int_q, ur_fin_q;
  logic             unused_wdata;

  // Software can reach only the two command bits. The indicator fields are
  // loaded only by received messages, so a message always wins over a write.
  assign abp_wr = reg_wr & reg_wdata[ABP_BIT] & endpoint_mode;
  assign ur_wr  = reg_wr & reg_wdata[UR_BIT];
  assign unused_wdata = ^{reg_wdata[CSR_W-1:ABP_BIT+1], reg_wdata[UR_BIT-1:0]};

  hpm_ind_capture #(.W(IND_W)) i_attn (
    .clk(clk), .rst_n(rst_n), .msg(rx_attn_msg), .code(rx_attn_code),
    .field(attn_q), .hit(attn_hit));

  hpm_ind_capture #(.W(IND_W)) i_pwr (
    .clk(clk), .rst_n(rst_n), .msg(rx_pwr_msg), .code(rx_pwr_code),
    .field(pwr_q), .hit(pwr_hit));

  hpm_tx_cmd i_abp (
    .clk(clk), .rst_n(rst_n), .set_req(abp_wr), .done(abp_done),
    .pend(abp_req), .finish(abp_fin));

  hpm_tx_cmd i_ur (
    .clk(clk), .rst_n(rst_n), .set_req(ur_wr), .done(ur_done),
    .pend(ur_req), .finish(ur_fin));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hp_int_q <= 1'b0;
      ur_fin_q <= 1'b0;
    end else begin
      hp_int_q <= attn_hit | pwr_hit;
      ur_fin_q <= ur_fin;
    end
  end

  assign hp_int_set = hp_int_q;
  assign hdr_copy   = ur_fin_q;
  assign ur_err_set = ur_fin_q;
  assign reg_rdata  = pack_csr(attn_q, pwr_q, abp_req, ur_req);

  AST_INT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_attn_msg || rx_pwr_msg) |=> hp_int_set); // R4
  AST_INT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_attn_msg || rx_pwr_msg) |=> !hp_int_set); // R4
  AST_ABP_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    !endpoint_mode && !abp_req |=> !abp_req); // R5
  AST_UR_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    ur_req && ur_done |=> hdr_copy && ur_err_set); // R8
  AST_UR_NO_STRAY: assert property (@(posedge clk) disable iff (!rst_n)
    !ur_req |=> !hdr_copy); // R8
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> reg_rdata[27:16] == 12'h000 && reg_rdata[13:0] == 14'h0000); // R9
endmodule

// File: tb/test_hpm_csr.sv
module test_hpm_csr;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        endpoint_mode;
  logic        reg_wr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        rx_attn_msg, rx_pwr_msg;
  logic [1:0]  rx_attn_code, rx_pwr_code;
  logic        hp_int_set, abp_req, abp_done, ur_req, ur_done, hdr_copy, ur_err_set;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  hpm_csr i_hpm_csr (
    .clk(clk), .rst_n(rst_n), .endpoint_mode(endpoint_mode),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rx_attn_msg(rx_attn_msg), .rx_attn_code(rx_attn_code),
    .rx_pwr_msg(rx_pwr_msg), .rx_pwr_code(rx_pwr_code),
    .hp_int_set(hp_int_set), .abp_req(abp_req), .abp_done(abp_done),
    .ur_req(ur_req), .ur_done(ur_done), .hdr_copy(hdr_copy), .ur_err_set(ur_err_set));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic idle();
    reg_wr = 0; reg_wdata = '0; rx_attn_msg = 0; rx_pwr_msg = 0;
    abp_done = 0; ur_done = 0;
  endtask

  // Expected contents worked out from the field positions in the requirements.
  function automatic logic [31:0] model(input logic [1:0] a, input logic [1:0] p,
                                        input logic b, input logic u);
    return (32'(a) << 30) | (32'(p) << 28) | (32'(b) << 15) | (32'(u) << 14);
  endfunction

  task automatic wr(input logic [31:0] d);
    reg_wr = 1; reg_wdata = d; cyc(); idle();
  endtask

  logic [1:0] ea, ep;

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 0; endpoint_mode = 1; rx_attn_code = 0; rx_pwr_code = 0;
    idle();
    repeat (3) cyc();
    chk("R1 rdata", reg_rdata, 32'h0);
    chk("R1 outputs", {27'b0, abp_req, ur_req, hp_int_set, hdr_copy, ur_err_set}, 32'h0);
    rst_n = 1; cyc();
    ea = 0; ep = 0;

    // R3 R10: every code into each field, against a write of the inverted code
    for (int f = 0; f < 2; f++) begin
      for (int c = 0; c < 4; c++) begin
        if (f == 0) begin rx_attn_msg = 1; rx_attn_code = 2'(c); ea = 2'(c); end
        else        begin rx_pwr_msg  = 1; rx_pwr_code  = 2'(c); ep = 2'(c); end
        reg_wr = 1; reg_wdata = {~2'(c), ~2'(c), 28'h0};
        cyc(); idle();
        chk("R3 R10 capture", reg_rdata, model(ea, ep, 0, 0));
        chk("R4 int pulse", 32'(hp_int_set), 32'h1);
        cyc();
        chk("R4 int width", 32'(hp_int_set), 32'h0);
      end
    end

    // R3: both fields in the same cycle with different codes
    rx_attn_msg = 1; rx_attn_code = 2'b01; rx_pwr_msg = 1; rx_pwr_code = 2'b10;
    cyc(); idle(); ea = 2'b01; ep = 2'b10;
    chk("R3 dual", reg_rdata, model(ea, ep, 0, 0));
    chk("R4 dual int", 32'(hp_int_set), 32'h1);
    cyc();
    chk("R4 dual single", 32'(hp_int_set), 32'h0);

    // R2: software cannot change the indicator fields
    wr(32'hF000_0000);
    chk("R2 read-only", reg_rdata, model(ea, ep, 0, 0));
    chk("R2 no int", 32'(hp_int_set), 32'h0);

    // R9: reserved bits
    wr(32'h0FFF_3FFF);
    chk("R9 reserved", reg_rdata, model(ea, ep, 0, 0));
    chk("R9 no req", {30'b0, abp_req, ur_req}, 32'h0);

    // R5: mode gating
    endpoint_mode = 0;
    wr(32'h0000_8000);
    chk("R5 gated", {31'b0, abp_req}, 32'h0);
    chk("R5 gated rd", reg_rdata, model(ea, ep, 0, 0));
    endpoint_mode = 1;
    wr(32'h0000_8000);
    chk("R5 set", {31'b0, abp_req}, 32'h1);
    chk("R5 set rd", reg_rdata, model(ea, ep, 1, 0));

    // R7: writing 0 or 1 again does not change the pending command
    wr(32'h0000_0000);
    chk("R7 no cancel", {31'b0, abp_req}, 32'h1);
    wr(32'h0000_8000);
    repeat (3) cyc();
    chk("R6 held", {31'b0, abp_req}, 32'h1);
    abp_done = 1; cyc(); idle();
    chk("R6 cleared", reg_rdata, model(ea, ep, 0, 0));
    repeat (3) cyc();
    chk("R7 no second", {31'b0, abp_req}, 32'h0);
    abp_done = 1; cyc(); idle();
    chk("R6 stray done", {31'b0, abp_req}, 32'h0);

    // R10: a write of 1 in the same cycle as done leaves the command clear
    wr(32'h0000_8000);
    reg_wr = 1; reg_wdata = 32'h0000_8000; abp_done = 1; cyc(); idle();
    chk("R10 done wins", {31'b0, abp_req}, 32'h0);

    // R8: unsupported-request reply
    ur_done = 1; cyc(); idle();
    cyc();
    chk("R8 stray no copy", {30'b0, hdr_copy, ur_err_set}, 32'h0);
    wr(32'h0000_4000);
    chk("R8 set", reg_rdata, model(ea, ep, 0, 1));
    wr(32'h0000_0000);
    repeat (2) cyc();
    chk("R8 hold", {29'b0, ur_req, hdr_copy, ur_err_set}, 32'h4);
    ur_done = 1; cyc(); idle();
    chk("R8 strobes", {29'b0, ur_req, hdr_copy, ur_err_set}, 32'h3);
    cyc();
    chk("R8 strobe width", {29'b0, ur_req, hdr_copy, ur_err_set}, 32'h0);

    // R6: both commands pending at once, completed one after the other
    reg_wr = 1; reg_wdata = 32'h0000_C000; cyc(); idle();
    chk("R6 both", reg_rdata, model(ea, ep, 1, 1));
    ur_done = 1; cyc(); idle();
    chk("R6 ur only", reg_rdata, model(ea, ep, 1, 0));
    abp_done = 1; cyc(); idle();
    chk("R6 abp then", reg_rdata, model(ea, ep, 0, 0));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule